// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block watches up to eight asynchronous interrupt pins and turns each of them into a clean, clock-domain interrupt request. Each pin is first passed through a synchroniser. It is then judged against its own programmable sense mode: falling edge, rising edge, low level, high level or both edges. When a pin's condition is met, a pending flag is latched for it.

Software controls the block through a single-cycle register port with five registers. Sense and priority are read/write. Pending can be read, and software clears it by writing zeros. Mask-set and mask-clear are write-only.

A pin raises its own output only when three things hold: its flag is pending, it is unmasked, and its 4-bit priority field is nonzero. A combined output ORs all the per-pin outputs together. Register fields are laid out MSB-first, so pin 0 occupies the most significant field or bit of every register.

Top module: `extint_ctrl`

## Requirements
- R1: Each pin passes through a two-flop synchroniser and then an edge detector. A pin change made before rising edge E1 sets the pending flag at edge E3 and appears on `irq_o` at edge E4.
- R2: The sense register is at address 0. Pin k's field begins at bit 32-(k+1)*SENSE_W, and SENSE_W is 2 or 4. The codes are 0 falling edge, 1 rising edge, 2 low level, 3 high level and 4 both edges; code 4 does not fit a 2-bit field. The register reads back only the pin fields, and every other bit reads 0.
- R3: A sense code above 4 detects nothing, so the pin never becomes pending.
- R4: In a level mode the pending flag is set again on every cycle that the level stays active. A clear written while the level persists therefore has no lasting effect.
- R5: The pending register is at address 2, with pin k at bit 7-k. Writing 0 to a bit clears that flag and writing 1 leaves it unchanged. Writing all zeros clears every flag.
- R6: Writing 1 to bit 7-k at address 3 masks pin k, and writing 1 to bit 7-k at address 4 unmasks it. A 0 bit has no effect in either register. A mask change shows on `irq_o` one edge after the write edge.
- R7: The priority register is at address 1, with a 4-bit field for pin k at bit 32-(k+1)*4. A zero field blocks the pin's output and any nonzero value passes it. Priority does not affect the pending flag.
- R8: `irq_any_o` is the OR of all bits of `irq_o` in the same cycle.
- R9: After reset every pin is masked, every priority and sense field is 0, no flag is pending and both outputs are low.
- R10: Read data is registered and is valid after the edge on which `bus_re` is sampled. Addresses 3 to 7 read as 0, and writes to addresses 5 to 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NPINS | Asynchronous interrupt pins |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | NPINS | Per-pin interrupt outputs |
| irq_any_o | output | 1 | OR of all per-pin outputs |

## Verification
A pin change reaches the pending flag three edges after it is applied and reaches `irq_o` four edges after. The bench checks this exact edge count once, sampling on falling edges just before and just after the due edge. Register writes that change the mask or priority take effect on `irq_o` one edge after the write edge, so those checks wait exactly one further edge. The sense-mode sweep lets at least six cycles pass after each pin transition or clear before it reads pending and the outputs, which covers the full four-edge path with margin.

// File: rtl/extint_pkg.sv
package extint_pkg;
  localparam int PIN_MAX = 8;
  localparam int REG_W   = 32;
  localparam int PRIO_W  = 4;

  localparam logic [2:0] A_SENSE = 3'd0;
  localparam logic [2:0] A_PRIO  = 3'd1;
  localparam logic [2:0] A_PEND  = 3'd2;
  localparam logic [2:0] A_MSET  = 3'd3;
  localparam logic [2:0] A_MCLR  = 3'd4;

  typedef enum logic [2:0] {
    SN_FALL = 3'd0,
    SN_RISE = 3'd1,
    SN_LOW  = 3'd2,
    SN_HIGH = 3'd3,
    SN_BOTH = 3'd4
  } sense_e;

  // Lowest bit of pin k's field when fields of width w are packed from the top.
  function automatic int field_lsb(input int k, input int w);
    return REG_W - (k + 1) * w;
  endfunction
endpackage

// File: rtl/extint_pin_detect.sv
module extint_pin_detect #(
  parameter int SENSE_W     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pin_i,
  input  logic [SENSE_W-1:0] mode_i,
  output logic               hit_o
);
  import extint_pkg::*;

  localparam int CW = (SENSE_W > 3) ? SENSE_W : 3;

  // chain[SYNC_STAGES-1] is the synchronised level; chain[SYNC_STAGES] the previous one
  logic [SYNC_STAGES:0] chain;
  logic cur, prev;
  logic [CW-1:0] code;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[SYNC_STAGES-1:0], pin_i};
  end

  assign cur  = chain[SYNC_STAGES-1];
  assign prev = chain[SYNC_STAGES];
  assign code = CW'(mode_i);

  always_comb begin
    case (code)
      CW'(SN_FALL): hit_o = prev & ~cur;
      CW'(SN_RISE): hit_o = cur & ~prev;
      CW'(SN_LOW):  hit_o = ~cur;
      CW'(SN_HIGH): hit_o = cur;
      CW'(SN_BOTH): hit_o = cur ^ prev;
      default:      hit_o = 1'b0;
    endcase
  end

  // A single-edge mode reports one cycle per transition
  AST_EDGE_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    ((code == CW'(SN_FALL) || code == CW'(SN_RISE)) && hit_o)
      |=> (!hit_o || mode_i != $past(mode_i))); // R2
endmodule

// File: rtl/extint_regs.sv
module extint_regs #(
  parameter int NPINS   = 8,
  parameter int SENSE_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic                     re,
  input  logic [2:0]               addr,
  input  logic [31:0]              wdata,
  input  logic [NPINS-1:0]         pend_i,
  output logic [31:0]              rdata_o,
  output logic [NPINS*SENSE_W-1:0] mode_o,
  output logic [NPINS-1:0]         prio_nz_o,
  output logic [NPINS-1:0]         mask_o,
  output logic [NPINS-1:0]         pend_keep_o
);
  import extint_pkg::*;

  logic [NPINS*SENSE_W-1:0] sense_q;
  logic [NPINS*PRIO_W-1:0]  prio_q;
  logic [NPINS-1:0]         mask_q;
  logic [31:0]              rd_mux;

  logic wr_sense, wr_prio, wr_pend, wr_mset, wr_mclr;
  assign wr_sense = we && addr == A_SENSE;
  assign wr_prio  = we && addr == A_PRIO;
  assign wr_pend  = we && addr == A_PEND;
  assign wr_mset  = we && addr == A_MSET;
  assign wr_mclr  = we && addr == A_MCLR;

  for (genvar k = 0; k < NPINS; k++) begin : g_pin
    localparam int SL  = field_lsb(k, SENSE_W);
    localparam int PL  = field_lsb(k, PRIO_W);
    localparam int BIT = PIN_MAX - 1 - k;

    always_ff @(posedge clk) begin
      if (rst) begin
        sense_q[k*SENSE_W +: SENSE_W] <= '0;
        prio_q[k*PRIO_W +: PRIO_W]    <= '0;
        mask_q[k]                     <= 1'b1;
      end else begin
        if (wr_sense) sense_q[k*SENSE_W +: SENSE_W] <= wdata[SL +: SENSE_W];
        if (wr_prio)  prio_q[k*PRIO_W +: PRIO_W]    <= wdata[PL +: PRIO_W];
        if (wr_mset && wdata[BIT])      mask_q[k] <= 1'b1;
        else if (wr_mclr && wdata[BIT]) mask_q[k] <= 1'b0;
      end
    end

    assign pend_keep_o[k] = !(wr_pend && !wdata[BIT]);
    assign prio_nz_o[k]   = |prio_q[k*PRIO_W +: PRIO_W];

    AST_MASK_SET: assert property (@(posedge clk) disable iff (rst)
      (wr_mset && wdata[BIT]) |=> mask_o[k]); // R6
    AST_MASK_CLR: assert property (@(posedge clk) disable iff (rst)
      (wr_mclr && wdata[BIT]) |=> !mask_o[k]); // R6
  end

  assign mode_o = sense_q;
  assign mask_o = mask_q;

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_SENSE: for (int i = 0; i < NPINS; i++)
                 rd_mux[field_lsb(i, SENSE_W) +: SENSE_W] = sense_q[i*SENSE_W +: SENSE_W];
      A_PRIO:  for (int i = 0; i < NPINS; i++)
                 rd_mux[field_lsb(i, PRIO_W) +: PRIO_W] = prio_q[i*PRIO_W +: PRIO_W];
      A_PEND:  for (int i = 0; i < NPINS; i++)
                 rd_mux[PIN_MAX-1-i] = pend_i[i];
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata_o <= '0;
    else if (re) rdata_o <= rd_mux;
  end
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl #(
  parameter int NPINS   = 8,
  parameter int SENSE_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pin_i,
  input  logic             bus_we,
  input  logic             bus_re,
  input  logic [2:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic [NPINS-1:0] irq_o,
  output logic             irq_any_o
);
  import extint_pkg::*;

  logic [NPINS*SENSE_W-1:0] mode;
  logic [NPINS-1:0] hit, pend, pend_keep, mask, prio_nz, fire;

  for (genvar k = 0; k < NPINS; k++) begin : g_det
    extint_pin_detect #(.SENSE_W(SENSE_W), .SYNC_STAGES(2)) i_det (
      .clk   (clk),
      .rst   (rst),
      .pin_i (pin_i[k]),
      .mode_i(mode[k*SENSE_W +: SENSE_W]),
      .hit_o (hit[k])
    );
  end

  extint_regs #(.NPINS(NPINS), .SENSE_W(SENSE_W)) i_regs (
    .clk        (clk),
    .rst        (rst),
    .we         (bus_we),
    .re         (bus_re),
    .addr       (bus_addr),
    .wdata      (bus_wdata),
    .pend_i     (pend),
    .rdata_o    (bus_rdata),
    .mode_o     (mode),
    .prio_nz_o  (prio_nz),
    .mask_o     (mask),
    .pend_keep_o(pend_keep)
  );

  // A detection in the cycle of a clear wins, so an active level re-latches
  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= (pend & pend_keep) | hit;
  end

  assign fire = pend & ~mask & prio_nz;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o     <= '0;
      irq_any_o <= 1'b0;
    end else begin
      irq_o     <= fire;
      irq_any_o <= |fire;
    end
  end

  for (genvar k = 0; k < NPINS; k++) begin : g_chk
    AST_PEND_CAUSE: assert property (@(posedge clk) disable iff (rst)
      $rose(pend[k]) |-> $past(hit[k])); // R1
    AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (rst)
      (!pend_keep[k] && !hit[k]) |=> !pend[k]); // R5
    AST_OUT_GATE: assert property (@(posedge clk) disable iff (rst)
      irq_o[k] |-> $past(!mask[k] && prio_nz[k] && pend[k])); // R7
  end

  AST_ANY_OR: assert property (@(posedge clk) disable iff (rst)
    irq_any_o == (|irq_o)); // R8
endmodule

// File: tb/test_extint_ctrl.sv
module test_extint_ctrl;
  localparam int CYC = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] pins = '0;
  logic [3:0] pins2 = '0;
  logic we = 1'b0, re = 1'b0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata2;
  logic [7:0] irq;
  logic [3:0] irq2;
  logic any, any2;
  int nchk = 0, nerr = 0;
  bit done = 0;

  always #(CYC/2) clk = ~clk;

  extint_ctrl #(.NPINS(8), .SENSE_W(4)) i_extint_ctrl (
    .clk(clk), .rst(rst), .pin_i(pins), .bus_we(we), .bus_re(re),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
    .irq_o(irq), .irq_any_o(any));

  extint_ctrl #(.NPINS(4), .SENSE_W(2)) i_extint_ctrl_w2 (
    .clk(clk), .rst(rst), .pin_i(pins2), .bus_we(we), .bus_re(re),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata2),
    .irq_o(irq2), .irq_any_o(any2));

  function automatic logic [31:0] fld(input int k, input int w, input logic [31:0] v);
    return v << (32 - (k + 1) * w);
  endfunction
  function automatic logic [31:0] pbit(input int k);
    return 32'h1 << (7 - k);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d, output logic [31:0] d2);
    @(negedge clk); re = 1'b1; addr = a;
    @(negedge clk); re = 1'b0; d = rdata; d2 = rdata2;
  endtask

  task automatic sweep_step(input string req, input int k, input logic ep);
    logic [31:0] r, r2;
    bus_rd(3'd2, r, r2);
    chk(req, r, ep ? pbit(k) : 32'h0);
    chk(req, {24'h0, irq}, ep ? (32'h1 << k) : 32'h0);
    chk("R8", {31'h0, any}, {31'h0, ep});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, r2;
    wcyc(4);
    rst = 1'b0;
    wcyc(2);

    // R9 reset state
    chk("R9 irq", {24'h0, irq}, 32'h0);
    chk("R9 any", {31'h0, any}, 32'h0);
    bus_rd(3'd0, r, r2); chk("R9 sense", r, 32'h0);
    bus_rd(3'd1, r, r2); chk("R9 prio", r, 32'h0);
    bus_rd(3'd2, r, r2); chk("R9 pend", r, 32'h0);
    // R9 all masked: low-level on every pin pends but stays silent
    bus_wr(3'd0, 32'h2222_2222);
    bus_wr(3'd1, 32'hFFFF_FFFF);
    wcyc(6);
    bus_rd(3'd2, r, r2); chk("R9 pend low level", r, 32'hFF);
    chk("R9 masked", {24'h0, irq}, 32'h0);
    bus_wr(3'd4, 32'hFF);
    wcyc(2);
    chk("R6 unmask all", {24'h0, irq}, 32'hFF);
    bus_wr(3'd0, 32'h0);
    bus_wr(3'd2, 32'h0);
    wcyc(6);
    chk("R5 clear all", {24'h0, irq}, 32'h0);

    // R10 write-only and unused addresses
    bus_rd(3'd3, r, r2); chk("R10 mset read", r, 32'h0);
    bus_rd(3'd4, r, r2); chk("R10 mclr read", r, 32'h0);
    bus_rd(3'd7, r, r2); chk("R10 unused read", r, 32'h0);
    bus_wr(3'd6, 32'hFFFF_FFFF);
    bus_rd(3'd0, r, r2); chk("R10 unused write", r, 32'h0);
    bus_rd(3'd1, r, r2); chk("R10 unused write prio", r, 32'hFFFF_FFFF);

    // R2/R4 sweep of all pins and valid codes
    for (int k = 0; k < 8; k++) begin
      for (int c = 0; c < 5; c++) begin
        bus_wr(3'd0, fld(k, 4, c));
        wcyc(6);
        bus_rd(3'd0, r, r2); chk("R2 readback", r, fld(k, 4, c));
        bus_wr(3'd2, 32'h0);
        wcyc(6);
        sweep_step("R2 idle low", k, c == 2);
        pins[k] = 1'b1; wcyc(6);
        sweep_step("R2 after rise", k, c == 2 || c == 1 || c == 4 || c == 3);
        bus_wr(3'd2, 32'h0); wcyc(6);
        sweep_step("R4 clear under high", k, c == 3);
        pins[k] = 1'b0; wcyc(6);
        sweep_step("R2 after fall", k, c == 3 || c == 0 || c == 4 || c == 2);
        bus_wr(3'd2, 32'h0); wcyc(6);
        sweep_step("R4 clear under low", k, c == 2);
      end
    end

    // R3 invalid codes
    for (int c = 5; c < 16; c++) begin
      bus_wr(3'd0, fld(0, 4, c));
      bus_wr(3'd2, 32'h0);
      pins[0] = 1'b1; wcyc(6);
      pins[0] = 1'b0; wcyc(6);
      bus_rd(3'd2, r, r2); chk("R3 invalid code pend", r, 32'h0);
      chk("R3 invalid code irq", {24'h0, irq}, 32'h0);
    end

    // R1 exact latency on pin 0, rising mode
    bus_wr(3'd0, fld(0, 4, 1));
    bus_wr(3'd2, 32'h0);
    wcyc(6);
    @(negedge clk); pins[0] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); chk("R1 before due edge", {31'h0, irq[0]}, 32'h0);
    @(posedge clk);
    @(negedge clk); chk("R1 at due edge", {31'h0, irq[0]}, 32'h1);
    pins[0] = 1'b0;
    bus_wr(3'd2, 32'h0);
    wcyc(6);

    // R6 mask set/clear on pin 3 held at high level
    bus_wr(3'd0, fld(3, 4, 3));
    pins[3] = 1'b1; wcyc(6);
    chk("R6 active", {24'h0, irq}, 32'h08);
    bus_wr(3'd3, 32'h0); wcyc(2);
    chk("R6 zero mset no effect", {24'h0, irq}, 32'h08);
    bus_wr(3'd3, pbit(3)); wcyc(1);
    chk("R6 masked next edge", {24'h0, irq}, 32'h0);
    chk("R8 masked", {31'h0, any}, 32'h0);
    bus_rd(3'd2, r, r2); chk("R6 pend kept", r, pbit(3));
    bus_wr(3'd4, 32'h0); wcyc(2);
    chk("R6 zero mclr no effect", {24'h0, irq}, 32'h0);
    bus_wr(3'd4, pbit(3)); wcyc(1);
    chk("R6 unmasked next edge", {24'h0, irq}, 32'h08);

    // R7 priority field gating
    bus_wr(3'd1, ~fld(3, 4, 4'hF)); wcyc(1);
    chk("R7 zero prio blocks", {24'h0, irq}, 32'h0);
    bus_rd(3'd2, r, r2); chk("R7 pend unaffected", r, pbit(3));
    bus_wr(3'd1, fld(3, 4, 1)); wcyc(1);
    chk("R7 nonzero passes", {24'h0, irq}, 32'h08);
    chk("R8 any", {31'h0, any}, 32'h1);
    bus_rd(3'd1, r, r2); chk("R7 readback", r, 32'h0001_0000);
    pins[3] = 1'b0;
    bus_wr(3'd1, 32'hFFFF_FFFF);

    // R5 write-one keeps, write-zero clears
    bus_wr(3'd0, fld(2, 4, 1) | fld(5, 4, 1));
    bus_wr(3'd2, 32'h0); wcyc(6);
    pins[2] = 1'b1; pins[5] = 1'b1; wcyc(6);
    bus_rd(3'd2, r, r2); chk("R5 two pending", r, pbit(2) | pbit(5));
    bus_wr(3'd2, ~pbit(5)); wcyc(1);
    bus_rd(3'd2, r, r2); chk("R5 selective clear", r, pbit(2));
    wcyc(1);
    chk("R5 irq after clear", {24'h0, irq}, 32'h04);
    bus_wr(3'd2, 32'h0); wcyc(1);
    bus_rd(3'd2, r, r2); chk("R5 clear all", r, 32'h0);
    pins = '0;
    wcyc(6);

    // R2 narrow 2-bit fields, four pins
    bus_wr(3'd0, fld(1, 2, 3));
    bus_wr(3'd1, 32'hFFFF_FFFF);
    bus_wr(3'd4, 32'hFF);
    wcyc(6);
    bus_wr(3'd2, 32'h0); wcyc(6);
    chk("R2 w2 idle", {28'h0, irq2}, 32'h0);
    bus_rd(3'd0, r, r2); chk("R2 w2 readback", r2, 32'h3000_0000);
    pins2[1] = 1'b1; wcyc(6);
    chk("R2 w2 high level", {28'h0, irq2}, 32'h2);
    bus_rd(3'd2, r, r2); chk("R2 w2 pend bit", r2, pbit(1));
    chk("R8 w2 any", {31'h0, any2}, 32'h1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule